// File: doc/BRIEF.md
# Circuit-Switched Crossbar Stage with Refusal and Retry

This block is one switching stage of an unbuffered, connection-oriented interconnect that carries remote memory references and messages between processors. Each of its N input ports can open a circuit to one of its N output ports. The first word of a transfer is a header. Its low-order bits name the output. If that output is free, the stage reserves it for the input. The stage drops the routing bits from the header, passes the rest on, and forwards every later word unchanged for as long as the input holds its valid signal high.

Each circuit has two directions. The reverse direction of the same circuit is reserved at the same moment as the forward one, so acknowledgements and replies from the far side come back over it with no separate arbitration. An input whose request cannot be met is refused. It sees a blocked status and must drop its valid signal and try again later. The stage stores no words and keeps no flow-control state. Forward and backward paths are each one register deep.

Every data path here is a plain valid-qualified stream with no ready signal. The stage never applies back-pressure. A word presented with valid high is either forwarded in the next cycle or, on a refused input, discarded. A sender learns of congestion only through the status pins, and the cost of that congestion is a retry.

Top module: `xbar_stage`

## Requirements
- R1: A header is the first word with valid high after a cycle with valid low, or after reset. Its low log2(N) bits select the output port. When the stage grants the header, that output shows valid high in the next cycle, with the header shifted right by log2(N) bits and zero-filled at the top.
- R2: While a granted input keeps valid high, each word it presents appears unchanged on its output one cycle later.
- R3: While an input holds a circuit during a cycle, its backward bus in the next cycle equals that cycle's backward input on its output port. Otherwise the backward bus is zero, and this includes the cycle right after the header.
- R4: A header aimed at an output that already carries a circuit is refused. The input's status reads BLOCKED (2'b10) in the next cycle and stays BLOCKED while valid stays high. The words it presents in that time reach no output.
- R5: Each output has its own round-robin arbiter for headers that arrive in the same cycle. After reset, input 0 has highest priority. After a grant to input k, priority starts at input k+1, wrapping to 0.
- R6: When the owning input drops valid, that output shows valid low in the next cycle. A header presented in that next cycle can win the output.
- R7: Status reads OPEN (2'b01) in the cycle after the input was granted or kept a circuit with valid high. It reads IDLE (2'b00) in the cycle after valid was low. The value 2'b11 never appears.
- R8: After reset, all outputs show valid low, all data and backward buses read zero, and all statuses read IDLE. An output with valid low drives zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Per-input word valid; low tears down the circuit |
| in_data | input | N_PORTS*FWD_W | Per-input forward words, input i at bits [i*FWD_W +: FWD_W] |
| in_bwd_data | output | N_PORTS*BWD_W | Per-input reply data returned over the circuit |
| in_status | output | N_PORTS*2 | Per-input status: 00 idle, 01 open, 10 blocked |
| out_valid | output | N_PORTS | Per-output word valid |
| out_data | output | N_PORTS*FWD_W | Per-output forward words |
| out_bwd_data | input | N_PORTS*BWD_W | Per-output reply data from the next stage |

## Verification
The bench builds the stage at its defaults: four ports, 16-bit forward and backward buses. With four ports the routing field is two bits wide, so the header shift shows up in every grant. Three inputs can contend for one output, which lets the bench walk the round-robin pointer through a wrap. All four inputs can also open circuits at once as a full permutation. A long run of random open, hold and drop traffic is then compared every cycle against a behavioural model. That run reaches back-to-back teardown and reuse, and refusal while another input holds the output.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    LINK_IDLE    = 2'b00,
    LINK_OPEN    = 2'b01,
    LINK_BLOCKED = 2'b10
  } link_status_e;

  typedef enum logic [1:0] {
    PS_FREE    = 2'b00,
    PS_HOLD    = 2'b01,
    PS_REFUSED = 2'b10
  } port_state_e;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N_REQ = 4,
  localparam int PW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant
);
  logic [PW-1:0] prio_q;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N_REQ; k++) begin
      int idx;
      idx = int'(prio_q) + k;
      if (idx >= N_REQ) idx = idx - N_REQ;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
        win        = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (found) begin
      prio_q <= (int'(win) == N_REQ - 1) ? '0 : win + PW'(1);
    end
  end
endmodule

// File: rtl/xbar_in_ctrl.sv
module xbar_in_ctrl
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [PW-1:0] req_port,
  input  logic          granted,
  output logic          conn_vld,
  output logic [PW-1:0] conn_port,
  output logic          hdr_req,
  output logic [1:0]    status
);
  port_state_e  state_q;
  logic [PW-1:0] port_q;
  link_status_e status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= PS_FREE;
      port_q   <= '0;
      status_q <= LINK_IDLE;
    end else if (!valid) begin
      state_q  <= PS_FREE;
      status_q <= LINK_IDLE;
    end else begin
      unique case (state_q)
        PS_FREE: begin
          if (granted) begin
            state_q  <= PS_HOLD;
            port_q   <= req_port;
            status_q <= LINK_OPEN;
          end else begin
            state_q  <= PS_REFUSED;
            status_q <= LINK_BLOCKED;
          end
        end
        PS_HOLD:    status_q <= LINK_OPEN;
        PS_REFUSED: status_q <= LINK_BLOCKED;
        default: begin
          state_q  <= PS_FREE;
          status_q <= LINK_IDLE;
        end
      endcase
    end
  end

  assign conn_vld  = (state_q == PS_HOLD);
  assign conn_port = port_q;
  assign hdr_req   = valid && (state_q == PS_FREE);
  assign status    = status_q;
endmodule

// File: rtl/xbar_stage.sv
module xbar_stage
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int FWD_W   = 16,
  parameter int BWD_W   = 16,
  localparam int PW     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS-1:0]       in_valid,
  input  logic [N_PORTS*FWD_W-1:0] in_data,
  output logic [N_PORTS*BWD_W-1:0] in_bwd_data,
  output logic [N_PORTS*2-1:0]     in_status,
  output logic [N_PORTS-1:0]       out_valid,
  output logic [N_PORTS*FWD_W-1:0] out_data,
  input  logic [N_PORTS*BWD_W-1:0] out_bwd_data
);
  logic [N_PORTS-1:0]         conn_vld;
  logic [PW-1:0]              conn_port [N_PORTS];
  logic [N_PORTS-1:0]         hdr_req;
  logic [N_PORTS-1:0]         granted;
  logic [N_PORTS-1:0]         grant_m   [N_PORTS];
  logic [N_PORTS-1:0]         req_m     [N_PORTS];
  logic [N_PORTS*N_PORTS-1:0] own_flat;
  logic [N_PORTS-1:0]         busy;

  // per-input connection tracking
  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
    xbar_in_ctrl #(.N_PORTS(N_PORTS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (in_valid[gi]),
      .req_port (in_data[gi*FWD_W +: PW]),
      .granted  (granted[gi]),
      .conn_vld (conn_vld[gi]),
      .conn_port(conn_port[gi]),
      .hdr_req  (hdr_req[gi]),
      .status   (in_status[gi*2 +: 2])
    );
  end

  // ownership matrix: own_flat[j*N + i] means input i holds output j
  always_comb begin
    for (int j = 0; j < N_PORTS; j++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        own_flat[j*N_PORTS + i] = conn_vld[i] && (int'(conn_port[i]) == j);
      end
      busy[j] = |own_flat[j*N_PORTS +: N_PORTS];
    end
  end

  // per-output request vectors and arbiters
  for (genvar gj = 0; gj < N_PORTS; gj++) begin : g_out
    always_comb begin
      for (int i = 0; i < N_PORTS; i++) begin
        req_m[gj][i] = hdr_req[i] && !busy[gj] &&
                       (int'(in_data[i*FWD_W +: PW]) == gj);
      end
    end

    xbar_rr_arb #(.N_REQ(N_PORTS)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_m[gj]),
      .grant(grant_m[gj])
    );

    logic             ov_d;
    logic [FWD_W-1:0] od_d;

    always_comb begin
      ov_d = 1'b0;
      od_d = '0;
      for (int i = 0; i < N_PORTS; i++) begin
        if (grant_m[gj][i]) begin
          ov_d = 1'b1;
          od_d = in_data[i*FWD_W +: FWD_W] >> PW;
        end else if (own_flat[gj*N_PORTS + i] && in_valid[i]) begin
          ov_d = 1'b1;
          od_d = in_data[i*FWD_W +: FWD_W];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid[gj]                 <= 1'b0;
        out_data[gj*FWD_W +: FWD_W]   <= '0;
      end else begin
        out_valid[gj]                 <= ov_d;
        out_data[gj*FWD_W +: FWD_W]   <= od_d;
      end
    end
  end

  // fold per-output grants back to each input
  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      granted[i] = 1'b0;
      for (int j = 0; j < N_PORTS; j++) begin
        granted[i] = granted[i] | grant_m[j][i];
      end
    end
  end

  // reverse path follows the held circuit
  for (genvar gb = 0; gb < N_PORTS; gb++) begin : g_bwd
    logic [BWD_W-1:0] bwd_d;
    always_comb begin
      bwd_d = '0;
      if (conn_vld[gb]) begin
        bwd_d = out_bwd_data[int'(conn_port[gb])*BWD_W +: BWD_W];
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) in_bwd_data[gb*BWD_W +: BWD_W] <= '0;
      else        in_bwd_data[gb*BWD_W +: BWD_W] <= bwd_d;
    end
  end
endmodule

// File: rtl/xbar_stage_chk.sv
module xbar_stage_chk #(
  parameter int N_PORTS = 4,
  parameter int BWD_W   = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_PORTS-1:0]           in_valid,
  input logic [N_PORTS*2-1:0]         in_status,
  input logic [N_PORTS*BWD_W-1:0]     in_bwd_data,
  input logic [N_PORTS-1:0]           out_valid,
  input logic [N_PORTS*N_PORTS-1:0]   own_flat
);
  for (genvar j = 0; j < N_PORTS; j++) begin : g_oc
    // R4: an output never carries two circuits
    a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_flat[j*N_PORTS +: N_PORTS]));
    for (genvar i = 0; i < N_PORTS; i++) begin : g_rel
      // R6: owner dropping valid silences its output next cycle
      a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (own_flat[j*N_PORTS + i] && !in_valid[i]) |=> !out_valid[j]);
    end
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_ic
    // R7: valid low gives IDLE next cycle
    a_r7_idle_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[i] |=> (in_status[i*2 +: 2] == 2'b00));
    // R7: encoding 11 is never produced
    a_r7_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      in_status[i*2 +: 2] != 2'b11);
    // R3: a blocked input receives no reply data
    a_r3_blocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (in_status[i*2 +: 2] == 2'b10) |-> (in_bwd_data[i*BWD_W +: BWD_W] == '0));
  end
endmodule

bind xbar_stage xbar_stage_chk #(.N_PORTS(N_PORTS), .BWD_W(BWD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_status  (in_status),
  .in_bwd_data(in_bwd_data),
  .out_valid  (out_valid),
  .own_flat   (own_flat)
);

// File: tb/xbar_stage_tb.sv
module xbar_stage_tb;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int B  = 16;
  localparam int PW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N*B-1:0] in_bwd_data;
  logic [N*2-1:0] in_status;
  logic [N-1:0]   out_valid;
  logic [N*W-1:0] out_data;
  logic [N*B-1:0] out_bwd_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xbar_stage #(.N_PORTS(N), .FWD_W(W), .BWD_W(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_bwd_data(in_bwd_data), .in_status(in_status), .out_valid(out_valid),
    .out_data(out_data), .out_bwd_data(out_bwd_data)
  );

  // behavioural reference: 0 free, 1 holding, 2 refused
  int         m_state [N];
  int         m_port  [N];
  int         m_prio  [N];
  logic       e_ov    [N];
  logic [W-1:0] e_od  [N];
  logic [B-1:0] e_bwd [N];
  logic [1:0] e_st    [N];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_state[i] = 0; m_port[i] = 0; m_prio[i] = 0;
        e_ov[i] = 0; e_od[i] = '0; e_bwd[i] = '0; e_st[i] = 2'b00;
      end
    end else begin
      int  winner [N];
      bit  busy   [N];
      int  ns     [N];
      for (int j = 0; j < N; j++) begin
        busy[j] = 0; winner[j] = -1;
        for (int i = 0; i < N; i++) if (m_state[i] == 1 && m_port[i] == j) busy[j] = 1;
      end
      for (int i = 0; i < N; i++)
        e_bwd[i] = (m_state[i] == 1) ? out_bwd_data[m_port[i]*B +: B] : '0;
      for (int j = 0; j < N; j++) begin
        if (!busy[j]) begin
          for (int k = 0; k < N; k++) begin
            int c;
            c = (m_prio[j] + k) % N;
            if (winner[j] < 0 && in_valid[c] && m_state[c] == 0 &&
                int'(in_data[c*W +: PW]) == j) winner[j] = c;
          end
          if (winner[j] >= 0) m_prio[j] = (winner[j] + 1) % N;
        end
      end
      for (int j = 0; j < N; j++) begin
        e_ov[j] = 0; e_od[j] = '0;
        if (winner[j] >= 0) begin
          e_ov[j] = 1; e_od[j] = in_data[winner[j]*W +: W] >> PW;
        end else begin
          for (int i = 0; i < N; i++)
            if (m_state[i] == 1 && m_port[i] == j && in_valid[i]) begin
              e_ov[j] = 1; e_od[j] = in_data[i*W +: W];
            end
        end
      end
      for (int i = 0; i < N; i++) begin
        ns[i] = m_state[i];
        if (!in_valid[i]) begin ns[i] = 0; e_st[i] = 2'b00; end
        else if (m_state[i] == 1) e_st[i] = 2'b01;
        else if (m_state[i] == 2) e_st[i] = 2'b10;
        else begin
          int p;
          p = int'(in_data[i*W +: PW]);
          if (winner[p] == i) begin ns[i] = 1; m_port[i] = p; e_st[i] = 2'b01; end
          else begin ns[i] = 2; e_st[i] = 2'b10; end
        end
      end
      for (int i = 0; i < N; i++) m_state[i] = ns[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    for (int j = 0; j < N; j++) begin
      chk(out_valid[j] == e_ov[j], "R6 out_valid vs model", out_valid[j], e_ov[j]);
      chk(out_data[j*W +: W] == e_od[j], "R2 out_data vs model", out_data[j*W +: W], e_od[j]);
    end
    for (int i = 0; i < N; i++) begin
      chk(in_bwd_data[i*B +: B] == e_bwd[i], "R3 bwd vs model", in_bwd_data[i*B +: B], e_bwd[i]);
      chk(in_status[i*2 +: 2] == e_st[i], "R7 status vs model", in_status[i*2 +: 2], e_st[i]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic drive(input int i, input bit v, input logic [W-1:0] d);
    in_valid[i] = v;
    in_data[i*W +: W] = d;
  endtask

  function automatic logic [1:0] st(input int i);
    return in_status[i*2 +: 2];
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk(out_valid == '0, "R8 out_valid after reset", out_valid, 0);
    chk(out_data == '0, "R8 out_data after reset", out_data[31:0], 0);
    chk(in_status == '0, "R8 status after reset", in_status, 0);
    chk(in_bwd_data == '0, "R8 bwd after reset", in_bwd_data[31:0], 0);

    out_bwd_data[2*B +: B] = 16'hCAFE;
    // R1 header to port 2
    drive(0, 1, 16'h1236);
    step();
    chk(out_valid[2] == 1'b1, "R1 grant valid", out_valid[2], 1);
    chk(out_data[2*W +: W] == 16'h048D, "R1 stripped header", out_data[2*W +: W], 16'h048D);
    chk(st(0) == 2'b01, "R7 open after grant", st(0), 1);
    chk(in_bwd_data[0 +: B] == '0, "R3 bwd zero after header", in_bwd_data[0 +: B], 0);

    drive(0, 1, 16'hBEEF);
    drive(1, 1, 16'h0002);
    step();
    chk(out_data[2*W +: W] == 16'hBEEF, "R2 body word", out_data[2*W +: W], 16'hBEEF);
    chk(st(1) == 2'b10, "R4 refused", st(1), 2);
    chk(in_bwd_data[0 +: B] == 16'hCAFE, "R3 reply over circuit", in_bwd_data[0 +: B], 16'hCAFE);

    drive(0, 1, 16'h5555);
    drive(1, 1, 16'h7777);
    step();
    chk(out_data[2*W +: W] == 16'h5555, "R4 refused words ignored", out_data[2*W +: W], 16'h5555);
    chk(st(1) == 2'b10, "R4 blocked held", st(1), 2);
    chk(in_bwd_data[B +: B] == '0, "R3 no reply when blocked", in_bwd_data[B +: B], 0);

    drive(0, 0, '0);
    drive(1, 0, '0);
    step();
    chk(out_valid[2] == 1'b0, "R6 torn down", out_valid[2], 0);
    chk(st(1) == 2'b00, "R7 idle after drop", st(1), 0);

    drive(1, 1, 16'h0006);
    step();
    chk(out_valid[2] == 1'b1 && out_data[2*W +: W] == 16'h0001, "R6 reuse next cycle",
        out_data[2*W +: W], 1);
    drive(1, 0, '0);
    step();

    // R5 round robin on port 1
    drive(1, 1, 16'h0005);
    drive(3, 1, 16'h0009);
    step();
    chk(st(1) == 2'b01 && st(3) == 2'b10, "R5 input1 wins first", st(1), 1);
    chk(out_data[W +: W] == 16'h0001, "R5 winner header", out_data[W +: W], 1);
    drive(1, 0, '0); drive(3, 0, '0);
    step();
    drive(1, 1, 16'h0005);
    drive(3, 1, 16'h000D);
    step();
    chk(st(3) == 2'b01 && st(1) == 2'b10, "R5 input3 wins second", st(3), 1);
    chk(out_data[W +: W] == 16'h0003, "R5 second header", out_data[W +: W], 3);
    drive(1, 0, '0); drive(3, 0, '0);
    step();
    drive(0, 1, 16'h0001);
    drive(1, 1, 16'h0005);
    drive(3, 1, 16'h0009);
    step();
    chk(st(0) == 2'b01 && st(1) == 2'b10 && st(3) == 2'b10, "R5 wrap to input0", st(0), 1);
    chk(out_data[W +: W] == 16'h0000, "R5 wrap header", out_data[W +: W], 0);
    for (int i = 0; i < N; i++) drive(i, 0, '0);
    step();

    // full permutation
    for (int i = 0; i < N; i++) drive(i, 1, 16'(((16 + i) << 2) | (N - 1 - i)));
    step();
    for (int i = 0; i < N; i++) begin
      chk(out_valid[N-1-i] == 1'b1 && out_data[(N-1-i)*W +: W] == 16'(16 + i),
          "R1 permutation", out_data[(N-1-i)*W +: W], 16 + i);
      chk(st(i) == 2'b01, "R7 permutation open", st(i), 1);
    end
    for (int i = 0; i < N; i++) drive(i, 0, '0);
    step();

    // random traffic compared against the model
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (in_valid[i]) begin
          if ($urandom_range(0, 5) == 0) drive(i, 0, '0);
          else drive(i, 1, 16'($urandom));
        end else if ($urandom_range(0, 2) == 0) drive(i, 1, 16'($urandom));
        out_bwd_data[i*B +: B] = 16'($urandom);
      end
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule